// File: doc/BRIEF.md
# Sticky Error Status Reporter

This block holds a 16-bit error status word whose four live flags latch on hardware events and stay set until software clears them by writing a 1 to the flag's position. The four sources are:

- a software-raised SMI request;
- a thermal sensor trip;
- a locked access to memory that does not map to DRAM;
- an overflow of pending memory refreshes, taken from an internal count of refreshes enqueued but not yet dequeued.

Each flag that rises from 0 to 1 can raise a single-cycle SERR pulse. It does so when the flag's own SERR mask bit and the global SERR enable are both set. The thermal flag also routes to SMI or SCI pulse outputs.

The thermal flag behaves differently from the others. It latches only when its message is actually sent. A message is sent only when exactly one of the three routes is enabled and the flag is not already set. Read data comes from a register, so it shows the status as it stood one cycle earlier.

Top module: `err_status_reg`

## Requirements
- R1: After reset the read data is 0000h and the `serr_o`, `smi_o` and `sci_o` outputs are low.
- R2: Bits 15:13, 10 and 7:0 always read as zero, and writing 1s to them changes nothing.
- R3: Bits 12, 11, 9 and 8 are sticky. Writing 1 to one of these positions clears that bit, and writing 0 leaves it unchanged.
- R4: `swsmi_evt_i` sets bit 12 and `lock_nondram_i` sets bit 9, whatever the SERR enables are.
- R5: `serr_o` pulses in the cycle after a flag goes from 0 to 1, but only if `serr_glob_en_i` and that flag's mask bit were set when the event arrived. The mask bits map as follows: [0] to bit 8, [1] to bit 9, [2] to bit 11, [3] to bit 12. A flag that is already set gives no new pulse.
- R6: The thermal routes are `smi_en_therm_i`, `sci_en_therm_i`, and `serr_mask_i[2]` together with `serr_glob_en_i`. If exactly one route is enabled, a trip pulses that route's output and sets bit 11. If zero routes or more than one route are enabled, no pulse is sent and bit 11 stays clear.
- R7: A thermal trip while bit 11 is already set sends no message.
- R8: The pending-refresh count rises on a push alone and falls on a pop alone. It holds when push and pop arrive together, when a pop arrives at zero, and when a push arrives at REF_LIMIT (1024). Bit 8 sets in the cycle the count reaches REF_LIMIT.
- R9: An event in the same cycle as a write-clear of its bit wins: the bit stays set, and the event counts as a new 0-to-1 transition that can send a message.
- R10: Message outputs are single-cycle pulses, and `rd_data_o` shows the status as it stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe (write-1-to-clear) |
| wr_data_i | input | 16 | Write data; each 1 clears the matching flag |
| rd_data_o | output | 16 | Status word, one cycle delayed |
| swsmi_evt_i | input | 1 | Software SMI event strobe |
| therm_trip_i | input | 1 | Thermal trip strobe |
| lock_nondram_i | input | 1 | Locked non-DRAM access strobe |
| refq_push_i | input | 1 | Refresh enqueue |
| refq_pop_i | input | 1 | Refresh dequeue |
| serr_glob_en_i | input | 1 | Global SERR enable |
| serr_mask_i | input | 4 | Per-flag SERR enables |
| smi_en_therm_i | input | 1 | Route thermal trips to SMI |
| sci_en_therm_i | input | 1 | Route thermal trips to SCI |
| serr_o | output | 1 | SERR message pulse |
| smi_o | output | 1 | SMI message pulse |
| sci_o | output | 1 | SCI message pulse |

## Verification
Directed sequences cover the following cases:
- a latched event with SERR disabled, to separate flag latching from reporting;
- writes of 0, writes to reserved positions and writes of 1, to separate the three write behaviours;
- a set that coincides with a clear;
- each thermal routing: single SMI, SCI or SERR, none, and more than one;
- a refresh count that stops one short of the limit and then reaches it, along with simultaneous push and pop and pops at zero.

A long random phase then mixes all strobes, masks and clears. This exposes mask-to-bit mapping errors and repeated-trip errors that the directed cases might only touch once.

// File: rtl/err_sts_pkg.sv
package err_sts_pkg;
  localparam int REG_W = 16;
  localparam int NSRC  = 4;
  localparam int SRC_RFSH  = 0;
  localparam int SRC_LOCK  = 1;
  localparam int SRC_THERM = 2;
  localparam int SRC_SWSMI = 3;
  // bit positions decoded by software
  localparam int BITPOS [NSRC] = '{8, 9, 11, 12};

  function automatic logic [REG_W-1:0] to_word(logic [NSRC-1:0] s);
    logic [REG_W-1:0] w;
    w = '0;
    for (int i = 0; i < NSRC; i++) w[BITPOS[i]] = s[i];
    return w;
  endfunction

  function automatic logic [NSRC-1:0] from_word(logic [REG_W-1:0] w);
    logic [NSRC-1:0] s;
    for (int i = 0; i < NSRC; i++) s[i] = w[BITPOS[i]];
    return s;
  endfunction
endpackage

// File: rtl/ref_pend_counter.sv
module ref_pend_counter #(
  parameter int LIMIT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic pop_i,
  output logic hit_o
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (push_i && !pop_i && cnt_q != LIM)       cnt_d = cnt_q + 1'b1;
    else if (pop_i && !push_i && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  assign hit_o = (cnt_d == LIM) && (cnt_q != LIM);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;

  assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);
  assert_cnt_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> $stable(cnt_q));
endmodule

// File: rtl/therm_router.sv
module therm_router (
  input  logic trip_i,
  input  logic prev_set_i,
  input  logic smi_en_i,
  input  logic sci_en_i,
  input  logic serr_en_i,
  output logic set_o,
  output logic smi_o,
  output logic sci_o
);
  logic [1:0] n_routes;
  logic       legal;

  assign n_routes = 2'(smi_en_i) + 2'(sci_en_i) + 2'(serr_en_i);
  assign legal    = (n_routes == 2'd1);
  assign set_o    = trip_i && legal && !prev_set_i;
  assign smi_o    = set_o && smi_en_i;
  assign sci_o    = set_o && sci_en_i;
endmodule

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o,
  output logic [N-1:0] rise_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic eff_prev;
    assign eff_prev  = sts_o[i] && !clr_i[i];
    assign rise_o[i] = set_i[i] && !eff_prev;

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) sts_o[i] <= 1'b0;
      else         sts_o[i] <= eff_prev || set_i[i];

    assert_sticky_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_o[i] && !clr_i[i]) |=> sts_o[i]);
    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> sts_o[i]);
  end
endmodule

// File: rtl/err_status_reg.sv
module err_status_reg
  import err_sts_pkg::*;
#(
  parameter int REF_LIMIT = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             swsmi_evt_i,
  input  logic             therm_trip_i,
  input  logic             lock_nondram_i,
  input  logic             refq_push_i,
  input  logic             refq_pop_i,
  input  logic             serr_glob_en_i,
  input  logic [NSRC-1:0]  serr_mask_i,
  input  logic             smi_en_therm_i,
  input  logic             sci_en_therm_i,
  output logic             serr_o,
  output logic             smi_o,
  output logic             sci_o
);
  localparam logic [REG_W-1:0] LIVE_MASK = to_word('1);

  logic [NSRC-1:0] clr, set, sts, rise;
  logic ref_hit, therm_set, therm_smi, therm_sci;

  assign clr = wr_en_i ? from_word(wr_data_i) : '0;

  ref_pend_counter #(.LIMIT(REF_LIMIT)) u_refcnt (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .push_i(refq_push_i), .pop_i(refq_pop_i), .hit_o(ref_hit)
  );

  therm_router u_therm (
    .trip_i    (therm_trip_i),
    .prev_set_i(sts[SRC_THERM] && !clr[SRC_THERM]),
    .smi_en_i  (smi_en_therm_i),
    .sci_en_i  (sci_en_therm_i),
    .serr_en_i (serr_mask_i[SRC_THERM] && serr_glob_en_i),
    .set_o     (therm_set),
    .smi_o     (therm_smi),
    .sci_o     (therm_sci)
  );

  always_comb begin
    set            = '0;
    set[SRC_RFSH]  = ref_hit;
    set[SRC_LOCK]  = lock_nondram_i;
    set[SRC_THERM] = therm_set;
    set[SRC_SWSMI] = swsmi_evt_i;
  end

  sticky_bank #(.N(NSRC)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(set), .clr_i(clr), .sts_o(sts), .rise_o(rise)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      serr_o    <= 1'b0;
      smi_o     <= 1'b0;
      sci_o     <= 1'b0;
      rd_data_o <= '0;
    end else begin
      serr_o    <= serr_glob_en_i && |(rise & serr_mask_i);
      smi_o     <= therm_smi;
      sci_o     <= therm_sci;
      rd_data_o <= to_word(sts);
    end

  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~LIVE_MASK) == '0);
  assert_serr_needs_glob_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_o |-> $past(serr_glob_en_i));
  assert_one_route_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(smi_o && sci_o));
  assert_smi_sets_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |=> rd_data_o[BITPOS[SRC_THERM]]);
endmodule

// File: tb/err_status_reg_test.sv
module err_status_reg_test;
  localparam int LIM = 1024;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 0; logic [15:0] wr_data = 0;
  logic sw = 0, trip = 0, lock = 0, push = 0, pop = 0;
  logic glob = 0; logic [3:0] mask = 0; logic smi_en = 0, sci_en = 0;
  logic [15:0] rd_data; logic serr, smi, sci;

  always #5 clk = ~clk;

  err_status_reg uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .swsmi_evt_i(sw), .therm_trip_i(trip),
    .lock_nondram_i(lock), .refq_push_i(push), .refq_pop_i(pop),
    .serr_glob_en_i(glob), .serr_mask_i(mask), .smi_en_therm_i(smi_en),
    .sci_en_therm_i(sci_en), .serr_o(serr), .smi_o(smi), .sci_o(sci)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [15:0] m_sts = 0;
  int m_cnt = 0;

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // bits: 8 refresh, 9 lock, 11 thermal, 12 sw smi; mask[0..3] maps to them
  function automatic logic [3:0] pick(logic [15:0] w);
    return {w[12], w[11], w[9], w[8]};
  endfunction
  function automatic logic [15:0] spread(logic [3:0] s);
    logic [15:0] w = '0;
    w[8] = s[0]; w[9] = s[1]; w[11] = s[2]; w[12] = s[3];
    return w;
  endfunction

  task automatic step();
    logic [3:0] clr, eff, set, rise;
    logic [15:0] prev_sts;
    int routes, ncnt;
    logic tset, ref_hit, e_serr;
    clr = wr_en ? pick(wr_data) : 4'b0;
    eff = pick(m_sts) & ~clr;
    ncnt = m_cnt;
    if (push && !pop && m_cnt < LIM) ncnt = m_cnt + 1;
    else if (pop && !push && m_cnt > 0) ncnt = m_cnt - 1;
    ref_hit = (ncnt == LIM) && (m_cnt != LIM);
    routes = int'(smi_en) + int'(sci_en) + int'(mask[2] && glob);
    tset = trip && routes == 1 && !eff[2];
    set = {sw, tset, lock, ref_hit};
    rise = set & ~eff;
    e_serr = glob && |(rise & mask);
    prev_sts = m_sts;
    @(posedge clk); #1;
    m_sts = spread(eff | set);
    m_cnt = ncnt;
    check(cur_req, "serr_o", {15'b0, serr}, {15'b0, e_serr});
    check(cur_req, "smi_o", {15'b0, smi}, {15'b0, tset && smi_en});
    check(cur_req, "sci_o", {15'b0, sci}, {15'b0, tset && sci_en});
    check("R10", "rd_data_o lag", rd_data, prev_sts);
    wr_en = 0; sw = 0; trip = 0; lock = 0; push = 0; pop = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(posedge clk);
    #1;
    cur_req = "R1";
    check("R1", "reset rd", rd_data, 16'h0);
    check("R1", "reset pulses", {13'b0, serr, smi, sci}, 16'h0);
    rst_ni = 1;
    idle(2);

    // R4: latch with reporting disabled
    cur_req = "R4";
    lock = 1; step(); sw = 1; step(); idle(1);
    check("R4", "bits latched", rd_data, 16'h1200);

    // R3/R2: write 0, reserved writes, then clear
    cur_req = "R3"; wr_en = 1; wr_data = 16'h0000; step(); idle(1);
    check("R3", "write 0 keeps", rd_data, 16'h1200);
    cur_req = "R2"; wr_en = 1; wr_data = 16'hE4FF; step(); idle(1);
    check("R2", "reserved write", rd_data, 16'h1200);
    cur_req = "R3"; wr_en = 1; wr_data = 16'h0200; step(); idle(1);
    check("R3", "w1c bit9", rd_data, 16'h1000);
    wr_en = 1; wr_data = 16'hFFFF; step(); idle(1);

    // R5: serr on rise only, one cycle (R10)
    cur_req = "R5"; glob = 1; mask = 4'b0010;
    lock = 1; step(); step();
    lock = 1; step(); idle(1);
    sw = 1; step(); idle(1);
    glob = 0; mask = 4'b1111; wr_en = 1; wr_data = 16'h1200; step();
    lock = 1; step(); idle(1);

    // R9: set wins over clear, new message
    cur_req = "R9"; glob = 1; mask = 4'b0010;
    lock = 1; wr_en = 1; wr_data = 16'h0200; step(); idle(1);
    check("R9", "bit9 kept", rd_data & 16'h0200, 16'h0200);
    wr_en = 1; wr_data = 16'hFFFF; step();

    // R6/R7 thermal routing
    cur_req = "R6"; glob = 0; mask = 0;
    smi_en = 1; trip = 1; step(); idle(1);
    cur_req = "R7"; trip = 1; step(); idle(1);
    cur_req = "R6"; wr_en = 1; wr_data = 16'h0800; step();
    sci_en = 1; trip = 1; step(); idle(1);
    check("R6", "illegal route bit11 clear", rd_data & 16'h0800, 16'h0);
    smi_en = 0; trip = 1; step(); idle(1);
    wr_en = 1; wr_data = 16'h0800; step();
    sci_en = 0; trip = 1; step(); idle(1);
    check("R6", "no route bit11 clear", rd_data & 16'h0800, 16'h0);
    glob = 1; mask = 4'b0100; trip = 1; step(); idle(1);
    cur_req = "R9"; wr_en = 1; wr_data = 16'h0800; trip = 1; step(); idle(1);
    wr_en = 1; wr_data = 16'hFFFF; step();

    // R8 refresh count
    cur_req = "R8"; mask = 4'b0001;
    for (int i = 0; i < LIM - 1; i++) begin push = 1; step(); end
    idle(1);
    check("R8", "below limit", rd_data & 16'h0100, 16'h0);
    push = 1; pop = 1; step(); idle(1);
    check("R8", "push+pop holds", rd_data & 16'h0100, 16'h0);
    push = 1; step(); idle(1);
    check("R8", "limit flag", rd_data & 16'h0100, 16'h0100);
    push = 1; step();
    wr_en = 1; wr_data = 16'h0100; step();
    pop = 1; step(); push = 1; step(); idle(1);
    for (int i = 0; i < LIM + 3; i++) begin pop = 1; step(); end

    // random mix
    cur_req = "R5";
    for (int i = 0; i < 4000; i++) begin
      glob   = $urandom_range(0, 3) != 0;
      mask   = 4'($urandom);
      smi_en = $urandom_range(0, 2) == 0;
      sci_en = $urandom_range(0, 2) == 0;
      sw     = $urandom_range(0, 9) == 0;
      lock   = $urandom_range(0, 9) == 0;
      trip   = $urandom_range(0, 5) == 0;
      push   = $urandom_range(0, 1) == 1;
      pop    = $urandom_range(0, 1) == 1;
      wr_en  = $urandom_range(0, 4) == 0;
      wr_data = 16'($urandom);
      step();
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule